// File: doc/BRIEF.md
# Bit-Pipelined Phase Accumulator Oscillator

This block is a numerically controlled oscillator whose phase accumulator is cut into one-bit pipeline slices so that every path between registers holds at most a full-adder cell. Each slice keeps its own sum bit and sends its carry to the slice above through a register. A carry therefore climbs one bit per clock.

On the way in, a triangular array of shift registers delays each bit of the frequency word so that it reaches its slice in the same cycle as the carry that belongs with it. On the way out, a mirrored triangular array delays the lower sum bits so that every bit of one logical phase sample leaves the block in the same cycle.

Seen from the ports, the block behaves like an ordinary `phase <= phase + freq` accumulator that is seen through a fixed delay. A new frequency word can be applied on any clock, and the phase stays exact when it changes.

Top module: `nco_bitpipe`

## Requirements
- R1: When `rst` is high at a rising edge, `phase_o` reads zero after that edge and every pipeline register, including the internal carries, is cleared.
- R2: Once the frequency word has been held constant for at least W clocks, `phase_o` advances by exactly that word, modulo 2^W, on every clock.
- R3: Bit i of the frequency word is consumed i clocks after it is sampled. Under a different word on every clock, `phase_o` equals an ideal full-width accumulator delayed by a fixed latency, with no corrupted samples.
- R4: A frequency word sampled at edge k first shows in `phase_o` after edge k+W-1. Before that edge the phase still reflects only the older words.
- R5: Accumulation wraps modulo 2^W and the carry out of bit W-1 is dropped, so an all-ones word makes `phase_o` decrease by one per clock.
- R6: A carry that ripples through all W bits, such as all-ones followed by one, gives a correctly aligned output word in every cycle.
- R7: A reset pulse in the middle of operation discards all samples in flight. Accumulation then restarts from zero and `phase_o` stays zero while the word is zero.
- R8: A frequency word of zero held for W clocks keeps `phase_o` stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| freq_i | input | W | Phase increment applied per clock, unsigned |
| phase_o | output | W | Aligned accumulated phase |

## Verification
The case that is hardest to reach from the ports is a carry that travels across the whole word while newer samples behind it are still only partly added. This happens when the frequency word changes while a long carry chain is in flight.

The stimulus forces it directly: it applies an all-ones word followed by one, after a reset so that the phase is known. It also runs long stretches where the word changes on every clock, drawn at random and mixed with the edge values one, all-ones and top-bit-only. Every cycle is compared against a delayed ideal accumulator.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned NCO_W_DEF = 32;

  // Number of delay registers on lane idx of a triangular array.
  // Forward arrays grow with the bit index; mirrored arrays shrink.
  function automatic int unsigned tap_depth(int unsigned idx, int unsigned w, bit rev);
    return rev ? (w - 1 - idx) : idx;
  endfunction
endpackage

// File: rtl/nco_tri_delay.sv
module nco_tri_delay #(
  parameter int unsigned W       = nco_pkg::NCO_W_DEF,
  parameter bit          REVERSE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    localparam int unsigned D = nco_pkg::tap_depth(i, W, REVERSE);
    if (D == 0) begin : g_pass
      assign q_o[i] = d_i[i];
    end else if (D == 1) begin : g_one
      logic r_q;
      always_ff @(posedge clk) begin
        if (rst) r_q <= 1'b0;
        else     r_q <= d_i[i];
      end
      assign q_o[i] = r_q;
    end else begin : g_chain
      logic [D-1:0] sr_q;
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[D-2:0], d_i[i]};
      end
      assign q_o[i] = sr_q[D-1];
    end
  end
endmodule

// File: rtl/nco_bit_slice.sv
module nco_bit_slice (
  input  logic clk,
  input  logic rst,
  input  logic a_i,
  input  logic c_i,
  output logic s_q,
  output logic c_q
);
  logic sum_d, cry_d;

  always_comb begin
    sum_d = s_q ^ a_i ^ c_i;
    cry_d = (s_q & a_i) | (s_q & c_i) | (a_i & c_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      s_q <= sum_d;
      c_q <= cry_d;
    end
  end
endmodule

// File: rtl/nco_bit_accum.sv
module nco_bit_accum #(
  parameter int unsigned W = nco_pkg::NCO_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] sum_q,
  output logic [W-2:0] carry_q
);
  logic [W-1:0] cin;
  assign cin[0]     = 1'b0;
  assign cin[W-1:1] = carry_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_slice
      nco_bit_slice u_slice (
        .clk (clk),
        .rst (rst),
        .a_i (addend_i[i]),
        .c_i (cin[i]),
        .s_q (sum_q[i]),
        .c_q (carry_q[i])
      );
    end else begin : g_msb
      // Top bit: carry out is discarded (modulo 2^W).
      logic msb_q;
      always_ff @(posedge clk) begin
        if (rst) msb_q <= 1'b0;
        else     msb_q <= msb_q ^ addend_i[i] ^ cin[i];
      end
      assign sum_q[i] = msb_q;
    end
  end
endmodule

// File: rtl/nco_bitpipe.sv
module nco_bitpipe #(
  parameter int unsigned W = nco_pkg::NCO_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] freq_i,
  output logic [W-1:0] phase_o
);
  logic [W-1:0] addend_skew;
  logic [W-1:0] sum_q;
  logic [W-2:0] carry_q;

  nco_tri_delay #(.W(W), .REVERSE(1'b0)) u_skew (
    .clk (clk),
    .rst (rst),
    .d_i (freq_i),
    .q_o (addend_skew)
  );

  nco_bit_accum #(.W(W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .addend_i (addend_skew),
    .sum_q    (sum_q),
    .carry_q  (carry_q)
  );

  nco_tri_delay #(.W(W), .REVERSE(1'b1)) u_deskew (
    .clk (clk),
    .rst (rst),
    .d_i (sum_q),
    .q_o (phase_o)
  );
endmodule

// File: rtl/nco_bitpipe_chk.sv
module nco_bitpipe_chk #(
  parameter int unsigned W = nco_pkg::NCO_W_DEF
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] freq_i,
  input logic [W-1:0] phase_o,
  input logic [W-2:0] carry_q
);
  localparam int unsigned CW = $clog2(W + 2);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] zero_run, same_run;
  logic [W-1:0]  held;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_run <= '0;
      same_run <= '0;
      held     <= '0;
    end else begin
      if (freq_i != '0)        zero_run <= '0;
      else if (zero_run != FULL) zero_run <= zero_run + 1'b1;
      if (freq_i != held)      same_run <= '0;
      else if (same_run != FULL) same_run <= same_run + 1'b1;
      held <= freq_i;
    end
  end

  // R1: output cleared one edge after reset
  a_r1_out_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> phase_o == '0);

  // R1: internal carries cleared by reset
  a_r1_carry_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> carry_q == '0);

  // R2: constant word gives a constant step
  a_r2_const_step: assert property (@(posedge clk) disable iff (rst)
    (same_run == FULL) |-> phase_o == $past(phase_o) + held);

  // R8: zero word holds the phase
  a_r8_zero_hold: assert property (@(posedge clk) disable iff (rst)
    (zero_run == FULL) |-> $stable(phase_o));
endmodule

bind nco_bitpipe nco_bitpipe_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .freq_i  (freq_i),
  .phase_o (phase_o),
  .carry_q (carry_q)
);

// File: tb/tb_nco_bitpipe.sv
module tb_nco_bitpipe;
  localparam int W = 32;

  logic         clk  = 1'b0;
  logic         rst  = 1'b1;
  logic [W-1:0] freq = '0;
  logic [W-1:0] phase;

  nco_bitpipe #(.W(W)) dut (
    .clk     (clk),
    .rst     (rst),
    .freq_i  (freq),
    .phase_o (phase)
  );

  always #10 clk = ~clk;

  // Ideal accumulator and its delay line (expected = hist[W-1]).
  logic [W-1:0] ideal;
  logic [W-1:0] hist [W];
  always @(posedge clk) begin
    if (rst) begin
      ideal <= '0;
      for (int j = 0; j < W; j++) hist[j] <= '0;
    end else begin
      ideal   <= ideal + freq;
      hist[0] <= ideal + freq;
      for (int j = 1; j < W; j++) hist[j] <= hist[j-1];
    end
  end

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R1";
  bit    scb_on = 1'b0;
  bit    done   = 1'b0;

  task automatic check(bit ok, string r, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (scb_on) check(phase === hist[W-1], tag, phase, hist[W-1]);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] pick_word(int k);
    case (k % 4)
      0:       return {{(W-1){1'b0}}, 1'b1};
      1:       return '1;
      2:       return {1'b1, {(W-1){1'b0}}};
      default: return $urandom();
    endcase
  endfunction

  initial begin
    logic [W-1:0] prev, x;
    void'($urandom(32'h5EED_0A17));

    // R1: reset state
    repeat (3) step();
    check(phase == '0, "R1", phase, '0);
    scb_on = 1'b1;
    rst = 1'b0;

    // R4: single-word impulse latency
    tag = "R4";
    x = 32'h1234_5678;
    freq = x;
    step();
    freq = '0;
    for (int j = 1; j <= W - 2; j++) step();
    check(phase == '0, "R4", phase, '0);
    step();
    check(phase == x, "R4", phase, x);

    // R2: constant word step
    tag = "R2";
    freq = $urandom();
    repeat (W) step();
    for (int j = 0; j < 3 * W; j++) begin
      prev = phase;
      step();
      check(phase - prev == freq, "R2", phase - prev, freq);
    end

    // R5: all-ones word wraps, decreasing by one
    tag = "R5";
    freq = '1;
    repeat (W) step();
    for (int j = 0; j < 2 * W; j++) begin
      prev = phase;
      step();
      check(prev - phase == 1, "R5", prev - phase, 1);
    end

    // R7: mid-run reset
    tag = "R7";
    rst = 1'b1;
    freq = $urandom();
    step();
    check(phase == '0, "R7", phase, '0);
    rst = 1'b0;
    freq = '0;
    for (int j = 0; j < W + 4; j++) begin
      step();
      check(phase == '0, "R7", phase, '0);
    end

    // R6: full-width carry ripple (all-ones then one)
    tag = "R6";
    freq = '1;
    step();
    freq = 1;
    step();
    freq = '0;
    for (int j = 1; j <= W - 2; j++) step();
    check(phase == '1, "R6", phase, '1);
    step();
    check(phase == '0, "R6", phase, '0);

    // R8: zero word holds the phase
    tag = "R8";
    freq = $urandom();
    repeat (W) step();
    freq = '0;
    repeat (W) step();
    for (int j = 0; j < 2 * W; j++) begin
      prev = phase;
      step();
      check(phase == prev, "R8", phase, prev);
    end

    // R3: a different word on every clock
    tag = "R3";
    for (int k = 0; k < 2000; k++) begin
      freq = ((k % 16) < 4) ? pick_word(k) : $urandom();
      step();
    end
    freq = '0;
    repeat (W + 2) step();

    scb_on = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s watchdog act=running exp=finished", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule